// File: doc/BRIEF.md
# Two-Way Interleaved Burst Memory Controller

This block serves four-word bursts of 32-bit data for a single requester. Behind it are two physical memory banks, modelled as internal arrays. Each bank has its own address, enable and data path, and a latency that can be set. The first access a bank makes in a burst costs a longer latency. Each later access to the same bank in that burst uses a shorter page-mode latency.

A mode input is sampled when a request is accepted and picks one of two mappings:

- **Interleaved mapping:** the lowest word-address bit chooses the bank. The two halves of a burst are then fetched at the same time, in pairs.
- **Linear mapping:** the upper half of the address space goes to the second bank. All four words of a burst then come from one bank in sequence.

Read words go back to the requester one per cycle, strictly in address order. A word that one bank delivers early waits in that bank's holding register until its turn. For a write, the controller first takes in all four data words, then stores them in the banks. A `done` strobe closes every burst.

Top module: `ilv_burst_ctrl`

## Requirements
- R1: A request is taken only on a clock edge where `ready` is high. `ready` is high only while idle. A `req_valid` raised during a burst changes neither that burst's timing nor the memory contents.
- R2: In interleaved mode, word address `a` is held in bank `a[0]` at row `a >> 1`.
- R3: In linear mode with `ROWS` words per bank, word address `a` below `ROWS` is held in bank 0 at row `a`. Any other address is held in bank 1 at row `a - ROWS`. Only one bank is ever active during a linear burst.
- R4: A read burst gives exactly four `rd_valid` strobes. Strobe k carries the word at start address plus k, for k from 0 to 3. A write burst gives no strobe.
- R5: In interleaved mode both banks begin their first access in the same cycle. With the default latencies of 3 and 1, counting cycle 1 as the cycle after the accepting edge:
  - read words appear in cycles 5, 6, 7 and 8, and `done` is high in cycle 9;
  - a write whose data words arrive in cycles 1 to 4 raises `done` in cycle 12.
- R6: A bank access takes `LAT_FIRST` cycles for the bank's first access in a burst and `LAT_PAGE` cycles after that. In linear mode with the defaults:
  - read words appear in cycles 5, 7, 9 and 11, and `done` is high in cycle 12;
  - a write raises `done` in cycle 16.
- R7: After a write request, the next four cycles with `wr_valid` high deliver data words 0 to 3, in order. `wr_valid` has no effect at any other time.
- R8: `done` stays high for exactly one cycle, and `ready` is high in the cycle that follows.
- R9: The two lowest bits of `req_addr` are ignored, so every burst starts on a four-word boundary.
- R10: After reset, `ready` is high and both `rd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ilv | input | 1 | 1 selects interleaved mapping, 0 selects linear mapping; sampled on accept |
| req_valid | input | 1 | Burst request |
| req_write | input | 1 | 1 for a write burst, 0 for a read burst |
| req_addr | input | 5 | Start word address (log2 of 2*ROWS bits) |
| wr_valid | input | 1 | Write data word valid |
| wr_data | input | 32 | Write data word |
| ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | A read word is present on rd_data |
| rd_data | output | 32 | Read data word |
| done | output | 1 | One-cycle end-of-burst strobe |

## Verification
The embedded assertions check the following on every cycle:
- both banks start together at the head of an interleaved burst;
- a linear burst never has both banks active at once;
- a bank is given a command only while it is idle;
- a holding register is never loaded while it is full;
- the idle state produces no output strobes, and `done` is a single pulse.

Only the bench's scenarios can show the rest:
- the cycle-exact word and completion timing in each mode;
- data coming back through the mapping in use, including words written under one mapping and read under the other;
- requests and `wr_valid` pulses that arrive at the wrong moment being ignored.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int WORD_W = 32;
    localparam int BEATS  = 4;
    localparam int BIDX_W = 2;
    localparam int NBANK  = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [BIDX_W-1:0] idx;
        word_t             data;
    } beat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_FIN
    } ctl_state_e;

    // Bank that holds a word address under the chosen mapping.
    function automatic logic bank_sel(input logic ilv, input logic [31:0] a,
                                      input int unsigned rows);
        if (ilv) return a[0];
        return (a >= rows);
    endfunction

    // Row inside the selected bank.
    function automatic logic [31:0] row_of(input logic ilv, input logic [31:0] a,
                                           input int unsigned rows);
        if (ilv) return a >> 1;
        if (a >= rows) return a - rows;
        return a;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int ROWS      = 16,
    parameter int LAT_FIRST = 3,
    parameter int LAT_PAGE  = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_vld,
    input  logic                     cmd_we,
    input  logic                     cmd_first,
    input  logic [$clog2(ROWS)-1:0]  cmd_row,
    input  logic [BIDX_W-1:0]        cmd_idx,
    input  word_t                    cmd_wdata,
    output logic                     busy,
    output logic                     ack,
    output beat_t                    ack_beat
);

    localparam int RW   = $clog2(ROWS);
    localparam int LMAX = (LAT_FIRST > LAT_PAGE) ? LAT_FIRST : LAT_PAGE;
    localparam int CW   = $clog2(LMAX + 1);

    word_t              mem [ROWS];
    logic [CW-1:0]      cnt_q;
    logic               we_q;
    logic [RW-1:0]      row_q;
    logic [BIDX_W-1:0]  idx_q;
    word_t              wd_q;
    logic               fire;

    assign fire = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            ack      <= 1'b0;
            cnt_q    <= '0;
            we_q     <= 1'b0;
            row_q    <= '0;
            idx_q    <= '0;
            wd_q     <= '0;
            ack_beat <= '0;
        end else begin
            ack <= 1'b0;
            if (cmd_vld && !busy) begin
                busy  <= 1'b1;
                cnt_q <= cmd_first ? CW'(LAT_FIRST - 1) : CW'(LAT_PAGE - 1);
                we_q  <= cmd_we;
                row_q <= cmd_row;
                idx_q <= cmd_idx;
                wd_q  <= cmd_wdata;
            end else if (fire) begin
                busy         <= 1'b0;
                ack          <= 1'b1;
                ack_beat.idx <= idx_q;
                if (!we_q) ack_beat.data <= mem[row_q];
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fire && we_q) mem[row_q] <= wd_q;
    end

    // R6: the controller only hands a command to an idle bank
    p_cmd_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> !busy);

    // R6: completion always ends a busy period
    p_ack_follows_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(busy));

endmodule

// File: rtl/ilv_beat_buf.sv
module ilv_beat_buf
    import ilv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  beat_t in_beat,
    input  logic  pop,
    output logic  head_vld,
    output beat_t head_beat
);

    logic  buf_v;
    beat_t buf_q;

    assign head_vld  = buf_v || in_vld;
    assign head_beat = buf_v ? buf_q : in_beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_v <= 1'b0;
            buf_q <= '0;
        end else if (buf_v && pop) begin
            buf_v <= 1'b0;
        end else if (in_vld && !pop) begin
            buf_v <= 1'b1;
            buf_q <= in_beat;
        end
    end

    // R4: an arriving word never lands on a word still waiting its turn
    p_buf_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> !buf_v);

endmodule

// File: rtl/ilv_burst_ctrl.sv
module ilv_burst_ctrl
    import ilv_pkg::*;
#(
    parameter int ROWS      = 16,
    parameter int LAT_FIRST = 3,
    parameter int LAT_PAGE  = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_ilv,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [$clog2(2*ROWS)-1:0]    req_addr,
    input  logic                         wr_valid,
    input  logic [WORD_W-1:0]            wr_data,
    output logic                         ready,
    output logic                         rd_valid,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         done
);

    localparam int AW = $clog2(2 * ROWS);
    localparam int RW = $clog2(ROWS);
    localparam int CW = BIDX_W + 1;

    ctl_state_e          state_q;
    logic                wr_q;
    logic                ilv_q;
    logic [AW-1:0]       base_q;
    word_t               wbuf [BEATS];
    logic [CW-1:0]       ld_cnt_q;
    logic [BEATS-1:0]    pend_q;
    logic [NBANK-1:0]    touched_q;
    logic [CW-1:0]       next_out_q;
    logic [CW-1:0]       retired_q;
    logic [CW-1:0]       retired_nxt;

    logic [BEATS-1:0]             beat_bank;
    logic [BEATS-1:0][RW-1:0]     beat_row;
    logic [NBANK-1:0]             bank_busy;
    logic [NBANK-1:0]             bank_ack;
    logic [NBANK-1:0]             issue;
    logic [NBANK-1:0]             pop;
    logic [NBANK-1:0][BEATS-1:0]  clr;
    logic [NBANK-1:0][WORD_W-1:0] head_data;
    logic [BEATS-1:0]             clr_all;
    logic                         running;

    assign running = (state_q == ST_RUN);
    assign ready   = (state_q == ST_IDLE);
    assign done    = (state_q == ST_FIN);

    // Address of every word of the burst, mapped to a bank and a row
    for (genvar i = 0; i < BEATS; i++) begin : g_beat
        logic [AW-1:0] a;
        assign a           = base_q + AW'(i);
        assign beat_bank[i] = bank_sel(ilv_q, 32'(a), ROWS);
        assign beat_row[i]  = RW'(row_of(ilv_q, 32'(a), ROWS));
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [BIDX_W-1:0] pick;
        logic              has;
        logic              head_vld;
        beat_t             head_beat;
        beat_t             ack_beat;

        // Lowest outstanding word that belongs to this bank
        always_comb begin
            pick = '0;
            has  = 1'b0;
            for (int i = BEATS - 1; i >= 0; i--) begin
                if (pend_q[i] && (beat_bank[i] == (b == 1))) begin
                    pick = BIDX_W'(i);
                    has  = 1'b1;
                end
            end
        end

        assign pop[b] = running && !wr_q && head_vld &&
                        (head_beat.idx == next_out_q[BIDX_W-1:0]);

        // Reads need room in the holding register; writes do not
        assign issue[b] = running && has && !bank_busy[b] &&
                          (wr_q || !head_vld || pop[b]);

        assign clr[b]       = issue[b] ? (BEATS'(1) << pick) : '0;
        assign head_data[b] = head_beat.data;

        ilv_bank #(
            .ROWS      (ROWS),
            .LAT_FIRST (LAT_FIRST),
            .LAT_PAGE  (LAT_PAGE)
        ) i_bank (
            .clk       (clk),
            .rst       (rst),
            .cmd_vld   (issue[b]),
            .cmd_we    (wr_q),
            .cmd_first (!touched_q[b]),
            .cmd_row   (beat_row[pick]),
            .cmd_idx   (pick),
            .cmd_wdata (wbuf[pick]),
            .busy      (bank_busy[b]),
            .ack       (bank_ack[b]),
            .ack_beat  (ack_beat)
        );

        ilv_beat_buf i_buf (
            .clk       (clk),
            .rst       (rst),
            .in_vld    (bank_ack[b] && !wr_q),
            .in_beat   (ack_beat),
            .pop       (pop[b]),
            .head_vld  (head_vld),
            .head_beat (head_beat)
        );
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        clr_all  = '0;
        for (int b = 0; b < NBANK; b++) begin
            clr_all = clr_all | clr[b];
            if (pop[b]) begin
                rd_valid = 1'b1;
                rd_data  = head_data[b];
            end
        end
    end

    always_comb begin
        retired_nxt = retired_q;
        if (rd_valid) retired_nxt = retired_nxt + CW'(1);
        for (int b = 0; b < NBANK; b++) begin
            if (wr_q && bank_ack[b]) retired_nxt = retired_nxt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            wr_q       <= 1'b0;
            ilv_q      <= 1'b0;
            base_q     <= '0;
            ld_cnt_q   <= '0;
            pend_q     <= '0;
            touched_q  <= '0;
            next_out_q <= '0;
            retired_q  <= '0;
            for (int i = 0; i < BEATS; i++) wbuf[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q       <= req_write;
                        ilv_q      <= mode_ilv;
                        base_q     <= req_addr & ~AW'(BEATS - 1);
                        pend_q     <= '1;
                        touched_q  <= '0;
                        next_out_q <= '0;
                        retired_q  <= '0;
                        ld_cnt_q   <= '0;
                        state_q    <= req_write ? ST_LOAD : ST_RUN;
                    end
                end
                ST_LOAD: begin
                    if (wr_valid) begin
                        wbuf[ld_cnt_q[BIDX_W-1:0]] <= wr_data;
                        ld_cnt_q <= ld_cnt_q + CW'(1);
                        if (ld_cnt_q == CW'(BEATS - 1)) state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    pend_q     <= pend_q & ~clr_all;
                    touched_q  <= touched_q | issue;
                    next_out_q <= next_out_q + CW'(rd_valid);
                    retired_q  <= retired_nxt;
                    if (retired_nxt == CW'(BEATS)) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: the idle state drives no read word and no completion
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!rd_valid && !done));

    // R8: completion lasts one cycle and returns to idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (ready && !done));

    // R5: both banks start together at the head of an interleaved burst
    p_pair_start_r5: assert property (@(posedge clk) disable iff (rst)
        (running && ilv_q && (touched_q == '0)) |=> (bank_busy == '1));

    // R3: a linear burst never keeps both banks active
    p_lin_one_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (running && !ilv_q) |-> (bank_busy != '1));

endmodule

// File: tb/test_ilv_burst_ctrl.sv
module test_ilv_burst_ctrl;
    import ilv_pkg::*;

    localparam int ROWS = 16;

    logic        clk;
    logic        rst;
    logic        mode_ilv;
    logic        req_valid;
    logic        req_write;
    logic [4:0]  req_addr;
    logic        wr_valid;
    logic [31:0] wr_data;
    logic        ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done;

    ilv_burst_ctrl #(.ROWS(ROWS), .LAT_FIRST(3), .LAT_PAGE(1)) i_ilv_burst_ctrl (
        .clk(clk), .rst(rst), .mode_ilv(mode_ilv), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .wr_valid(wr_valid),
        .wr_data(wr_data), .ready(ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;

    logic [31:0] m0 [ROWS];
    logic [31:0] m1 [ROWS];
    logic [31:0] last_d [4];

    typedef struct packed {
        logic       wr;
        logic       ilv;
        logic [4:0] addr;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b1, 5'd0,  8'h11},
        '{1'b1, 1'b0, 5'd20, 8'h22},
        '{1'b0, 1'b1, 5'd0,  8'h00},
        '{1'b0, 1'b0, 5'd20, 8'h00},
        '{1'b1, 1'b0, 5'd4,  8'h33},
        '{1'b0, 1'b1, 5'd8,  8'h00},
        '{1'b1, 1'b1, 5'd4,  8'h44},
        '{1'b0, 1'b0, 5'd0,  8'h00},
        '{1'b0, 1'b0, 5'd16, 8'h00},
        '{1'b1, 1'b1, 5'd28, 8'h55},
        '{1'b0, 1'b1, 5'd28, 8'h00}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic m_bank(input logic ilv, input int a);
        return ilv ? a[0] : (a >= ROWS);
    endfunction

    function automatic int m_row(input logic ilv, input int a);
        if (ilv) return a / 2;
        return (a >= ROWS) ? a - ROWS : a;
    endfunction

    task automatic run(input logic wr, input logic ilv, input logic [4:0] addr,
                       input logic [7:0] seed, input bit poke);
        logic [31:0] exp_d [4];
        int          exp_c [4];
        int          got_c [4];
        logic [4:0]  base;
        int          nb;
        int          cnt;
        int          dcyc;
        int          exp_done;
        string       tag;

        base = addr & 5'h1C;
        for (int k = 0; k < 4; k++) begin
            int a;
            a = int'(base) + k;
            if (wr) exp_d[k] = {seed, 8'(k), 3'b000, base, 8'h5A};
            else    exp_d[k] = m_bank(ilv, a) ? m1[m_row(ilv, a)] : m0[m_row(ilv, a)];
            exp_c[k] = ilv ? 5 + k : 5 + 2 * k;
            got_c[k] = 0;
            last_d[k] = '0;
        end
        tag = ilv ? "R5 R2 interleaved" : "R6 R3 linear";

        @(negedge clk);
        chk(ready == 1'b1, "R1 ready before request", 32'(ready), 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        mode_ilv  = ilv;
        req_addr  = addr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1; nb = 0; dcyc = 0;
        while (dcyc == 0 && cnt < 60) begin
            if (wr && cnt <= 4) begin
                wr_valid = 1'b1;
                wr_data  = exp_d[cnt-1];
            end else begin
                wr_valid = 1'b0;
                wr_data  = 32'hDEAD_0000 + 32'(cnt);
            end
            if (poke && cnt == 3) begin   // R1: request while busy
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = base;
                mode_ilv  = ~ilv;
                wr_valid  = 1'b1;
            end
            if (poke && cnt == 4) begin
                req_valid = 1'b0;
                wr_valid  = 1'b0;
            end
            if (rd_valid) begin
                if (nb < 4) begin
                    last_d[nb] = rd_data;
                    got_c[nb]  = cnt;
                end
                nb++;
            end
            if (done) dcyc = cnt;
            else begin
                @(posedge clk);
                @(negedge clk);
                cnt++;
            end
        end
        wr_valid  = 1'b0;
        req_valid = 1'b0;

        exp_done = wr ? (ilv ? 12 : 16) : (ilv ? 9 : 12);
        chk(dcyc == exp_done, {tag, " done cycle"}, 32'(dcyc), 32'(exp_done));
        chk(nb == (wr ? 0 : 4), "R4 read strobe count", 32'(nb), wr ? 32'd0 : 32'd4);
        if (!wr) begin
            for (int k = 0; k < 4; k++) begin
                chk(last_d[k] === exp_d[k], {"R4 ordered data, ", tag}, last_d[k], exp_d[k]);
                chk(got_c[k] == exp_c[k], {tag, " word cycle"}, 32'(got_c[k]), 32'(exp_c[k]));
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                int a;
                a = int'(base) + k;
                if (m_bank(ilv, a)) m1[m_row(ilv, a)] = exp_d[k];
                else                m0[m_row(ilv, a)] = exp_d[k];
            end
        end
        @(negedge clk);
        chk(ready && !done, "R8 single done then ready", {30'd0, ready, done}, 32'd2);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_ilv = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; wr_valid = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(ready == 1'b1, "R10 ready after reset", 32'(ready), 32'd1);
        chk(rd_valid == 1'b0, "R10 rd_valid after reset", 32'(rd_valid), 32'd0);
        chk(done == 1'b0, "R10 done after reset", 32'(done), 32'd0);

        for (int i = 0; i < 11; i++)
            run(VECS[i].wr, VECS[i].ilv, VECS[i].addr, VECS[i].seed, 1'b0);

        // R9: low address bits ignored
        run(1'b0, 1'b1, 5'd30, 8'h00, 1'b0);
        chk(last_d[0] == {8'h55, 8'd0, 3'b000, 5'd28, 8'h5A}, "R9 misaligned start",
            last_d[0], {8'h55, 8'd0, 3'b000, 5'd28, 8'h5A});

        // R1: request during a burst is ignored
        run(1'b0, 1'b1, 5'd0, 8'h00, 1'b1);
        run(1'b0, 1'b1, 5'd0, 8'h00, 1'b0);
        chk(last_d[0] == {8'h11, 8'd0, 8'h00, 8'h5A}, "R1 memory unchanged after busy request",
            last_d[0], {8'h11, 8'd0, 8'h00, 8'h5A});

        // R7: wr_valid while idle is ignored
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
        run(1'b1, 1'b1, 5'd12, 8'h66, 1'b0);
        run(1'b0, 1'b1, 5'd12, 8'h00, 1'b0);
        chk(last_d[0] == {8'h66, 8'd0, 3'b000, 5'd12, 8'h5A}, "R7 idle wr_valid ignored",
            last_d[0], {8'h66, 8'd0, 3'b000, 5'd12, 8'h5A});
        run(1'b0, 1'b0, 5'd12, 8'h00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule